// File: doc/BRIEF.md
# Demand Paging Page Table Manager

This block keeps the page table of a single process with eight virtual pages and serves the misses of a translation cache in front of it. A lookup either finds a resident page and returns its frame and dirty bit, or faults. On a fault the block hands the page a physical frame from a fixed pool of four contiguous frames (numbers 2 to 5) and writes the new mapping. It uses a free frame while one remains, and otherwise takes the frame of the resident page used longest ago.

When a frame is taken from another page, that page's entry is wiped. The fault response names the evicted page and whether it was modified, so the caller can drop it from its cache and model the write-back. The cache reports every reference it serves itself through a touch strobe, which keeps the page recency exact. It also reports writes through a dirty-mark strobe.

Every lookup is answered exactly one clock later. The mapping and recency updates take effect on the same edge that registers the answer.

Top module: `pgtbl_mgr`

## Requirements
- R1: After reset every entry is invalid and no response is shown, so the first lookup of any page faults.
- R2: A lookup of a resident page answers with rsp_fault low, the stored frame and the stored dirty bit, and no eviction. A write lookup that hits does not change the stored dirty bit.
- R3: While free frames remain, faults take them in increasing frame order (2, 3, 4, then 5) and report no eviction.
- R4: A new mapping starts with its dirty bit equal to req_write of the faulting lookup, and rsp_dirty shows that value.
- R5: With all four frames in use, a fault takes the frame of the least recently used resident page. The response carries that frame, evict_valid high, the victim page in evict_vpn and the victim's dirty bit in evict_dirty.
- R6: The victim's entry is cleared, so the next lookup of the victim faults.
- R7: A touch of a resident page makes it the most recently used. A touch of a non-resident page changes nothing.
- R8: A dirty mark sets the dirty bit of a resident page, and later hits show it. A dirty mark of a non-resident page is ignored.
- R9: rsp_valid is high in exactly the cycle after each lookup. Touch and dirty strobes give no response.
- R10: evict_valid is high only on a faulting response, and rsp_ppn is always within frames 2 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup strobe from the translation cache |
| req_vpn | input | 3 | Page number looked up |
| req_write | input | 1 | The lookup stems from a write access |
| touch_valid | input | 1 | Reference served by the cache (recency update) |
| touch_vpn | input | 3 | Page number referenced |
| dirty_valid | input | 1 | Dirty-mark strobe |
| dirty_vpn | input | 3 | Page number to mark modified |
| rsp_valid | output | 1 | Response valid, one cycle after a lookup |
| rsp_fault | output | 1 | The lookup faulted and a frame was assigned |
| rsp_ppn | output | 3 | Physical frame number of the page |
| rsp_dirty | output | 1 | Dirty bit of the page's entry |
| evict_valid | output | 1 | A resident page lost its frame in this fault |
| evict_vpn | output | 3 | Page number of the evicted page |
| evict_dirty | output | 1 | Evicted page was modified |

## Verification
The assertions assume that the caller raises at most one of the lookup, touch and dirty strobes in a cycle. The block still serves a lookup first and a dirty mark before a touch, but that ordering is not checked. The assertions also assume that req_write is held in the cycle its lookup is sampled. The random stimulus draws a single operation per step and holds each strobe for one cycle with its data steady. Directed cases cover the hand-out order of free frames, a recency change by touch, dirty marks on absent pages, and the refault of an evicted page.

// File: rtl/pgtbl_pkg.sv
package pgtbl_pkg;

  // Kind of answer registered for a lookup
  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_HIT   = 2'd1,
    RSP_FILL  = 2'd2,
    RSP_EVICT = 2'd3
  } rsp_kind_e;

endpackage

// File: rtl/pgtbl_pte_store.sv
module pgtbl_pte_store #(
  parameter int NUM_VPN = 8,
  parameter int PPN_W   = 3,
  localparam int VPN_W  = $clog2(NUM_VPN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] rd_a_vpn,
  output logic             rd_a_valid,
  output logic             rd_a_dirty,
  output logic [PPN_W-1:0] rd_a_ppn,
  input  logic [VPN_W-1:0] rd_b_vpn,
  output logic             rd_b_valid,
  output logic [PPN_W-1:0] rd_b_ppn,
  input  logic [VPN_W-1:0] rd_c_vpn,
  output logic             rd_c_dirty,
  input  logic             map_en,
  input  logic [VPN_W-1:0] map_vpn,
  input  logic [PPN_W-1:0] map_ppn,
  input  logic             map_dirty,
  input  logic             clr_en,
  input  logic [VPN_W-1:0] clr_vpn,
  input  logic             dset_en,
  input  logic [VPN_W-1:0] dset_vpn
);

  logic [NUM_VPN-1:0]            valid_q, valid_d;
  logic [NUM_VPN-1:0]            dirty_q, dirty_d;
  logic [NUM_VPN-1:0][PPN_W-1:0] ppn_q, ppn_d;
  logic                          upd_en;

  assign rd_a_valid = valid_q[rd_a_vpn];
  assign rd_a_dirty = dirty_q[rd_a_vpn];
  assign rd_a_ppn   = ppn_q[rd_a_vpn];
  assign rd_b_valid = valid_q[rd_b_vpn];
  assign rd_b_ppn   = ppn_q[rd_b_vpn];
  assign rd_c_dirty = dirty_q[rd_c_vpn];

  assign upd_en = map_en | clr_en | dset_en;

  // Per entry: dirty mark, then wipe, then new mapping (last wins)
  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    ppn_d   = ppn_q;
    for (int e = 0; e < NUM_VPN; e++) begin
      if (dset_en && (dset_vpn == VPN_W'(e)) && valid_q[e]) begin
        dirty_d[e] = 1'b1;
      end
      if (clr_en && (clr_vpn == VPN_W'(e))) begin
        valid_d[e] = 1'b0;
        dirty_d[e] = 1'b0;
        ppn_d[e]   = '0;
      end
      if (map_en && (map_vpn == VPN_W'(e))) begin
        valid_d[e] = 1'b1;
        dirty_d[e] = map_dirty;
        ppn_d[e]   = map_ppn;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ppn_q   <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      ppn_q   <= ppn_d;
    end
  end

endmodule

// File: rtl/pgtbl_frame_lru.sv
module pgtbl_frame_lru #(
  parameter int NUM_FRAMES = 4,
  parameter int VPN_W      = 3,
  localparam int FIDX_W    = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int CNT_W     = $clog2(NUM_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_en,
  input  logic [FIDX_W-1:0] touch_idx,
  input  logic              alloc_en,
  input  logic [VPN_W-1:0]  alloc_vpn,
  output logic [FIDX_W-1:0] pick_idx,
  output logic              pick_evict,
  output logic [VPN_W-1:0]  pick_vpn
);

  localparam logic [FIDX_W-1:0] AGE_MAX = FIDX_W'(NUM_FRAMES - 1);

  logic [NUM_FRAMES-1:0][FIDX_W-1:0] age_q, age_d;
  logic [NUM_FRAMES-1:0][VPN_W-1:0]  owner_q, owner_d;
  logic [CNT_W-1:0]                  fill_q, fill_d;
  logic                              full;
  logic [FIDX_W-1:0]                 oldest_idx;
  logic                              use_en;
  logic [FIDX_W-1:0]                 use_idx;
  logic [FIDX_W-1:0]                 use_age;

  assign full = (fill_q == CNT_W'(NUM_FRAMES));

  // The frame holding the largest age is the least recently used one
  always_comb begin
    oldest_idx = '0;
    for (int f = 0; f < NUM_FRAMES; f++) begin
      if (age_q[f] == AGE_MAX) oldest_idx = FIDX_W'(f);
    end
  end

  assign pick_idx   = full ? oldest_idx : fill_q[FIDX_W-1:0];
  assign pick_evict = full;
  assign pick_vpn   = owner_q[pick_idx];

  assign use_en  = alloc_en | touch_en;
  assign use_idx = alloc_en ? pick_idx : touch_idx;
  assign use_age = age_q[use_idx];

  always_comb begin
    age_d   = age_q;
    owner_d = owner_q;
    fill_d  = fill_q;
    for (int f = 0; f < NUM_FRAMES; f++) begin
      if (FIDX_W'(f) == use_idx) begin
        age_d[f] = '0;
      end else if (age_q[f] < use_age) begin
        age_d[f] = age_q[f] + 1'b1;
      end
    end
    if (alloc_en) begin
      owner_d[pick_idx] = alloc_vpn;
      if (!full) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FRAMES; f++) begin
        age_q[f]   <= AGE_MAX;
        owner_q[f] <= '0;
      end
      fill_q <= '0;
    end else if (use_en) begin
      age_q   <= age_d;
      owner_q <= owner_d;
      fill_q  <= fill_d;
    end
  end

endmodule

// File: rtl/pgtbl_mgr.sv
module pgtbl_mgr #(
  parameter int NUM_VPN    = 8,
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_BASE = 2,
  parameter int PPN_W      = 3,
  localparam int VPN_W     = $clog2(NUM_VPN),
  localparam int FIDX_W    = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  input  logic             touch_valid,
  input  logic [VPN_W-1:0] touch_vpn,
  input  logic             dirty_valid,
  input  logic [VPN_W-1:0] dirty_vpn,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_dirty,
  output logic             evict_valid,
  output logic [VPN_W-1:0] evict_vpn,
  output logic             evict_dirty
);
  import pgtbl_pkg::*;

  // Arbitration: lookup first, then dirty mark, then touch
  logic act_dirty, act_touch;
  assign act_dirty = dirty_valid & ~req_valid;
  assign act_touch = touch_valid & ~req_valid & ~dirty_valid;

  logic             a_valid, a_dirty, b_valid, c_dirty;
  logic [PPN_W-1:0] a_ppn, b_ppn;
  logic [FIDX_W-1:0] pick_idx;
  logic             pick_evict;
  logic [VPN_W-1:0] pick_vpn;

  logic hit, miss;
  assign hit  = req_valid &  a_valid;
  assign miss = req_valid & ~a_valid;

  logic [PPN_W-1:0] a_off, b_off, fill_ppn;
  assign a_off    = a_ppn - PPN_W'(FRAME_BASE);
  assign b_off    = b_ppn - PPN_W'(FRAME_BASE);
  assign fill_ppn = PPN_W'(FRAME_BASE) + PPN_W'(pick_idx);

  logic              lru_touch;
  logic [FIDX_W-1:0] lru_idx;
  assign lru_touch = hit | (act_touch & b_valid);
  assign lru_idx   = hit ? a_off[FIDX_W-1:0] : b_off[FIDX_W-1:0];

  pgtbl_pte_store #(
    .NUM_VPN (NUM_VPN),
    .PPN_W   (PPN_W)
  ) u_pte (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_vpn   (req_vpn),
    .rd_a_valid (a_valid),
    .rd_a_dirty (a_dirty),
    .rd_a_ppn   (a_ppn),
    .rd_b_vpn   (touch_vpn),
    .rd_b_valid (b_valid),
    .rd_b_ppn   (b_ppn),
    .rd_c_vpn   (pick_vpn),
    .rd_c_dirty (c_dirty),
    .map_en     (miss),
    .map_vpn    (req_vpn),
    .map_ppn    (fill_ppn),
    .map_dirty  (req_write),
    .clr_en     (miss & pick_evict),
    .clr_vpn    (pick_vpn),
    .dset_en    (act_dirty),
    .dset_vpn   (dirty_vpn)
  );

  pgtbl_frame_lru #(
    .NUM_FRAMES (NUM_FRAMES),
    .VPN_W      (VPN_W)
  ) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (lru_touch),
    .touch_idx  (lru_idx),
    .alloc_en   (miss),
    .alloc_vpn  (req_vpn),
    .pick_idx   (pick_idx),
    .pick_evict (pick_evict),
    .pick_vpn   (pick_vpn)
  );

  // Response next state
  rsp_kind_e        kind_q, kind_d;
  logic [PPN_W-1:0] ppn_q, ppn_d;
  logic             dirty_q, dirty_d;
  logic [VPN_W-1:0] vict_q, vict_d;
  logic             vdirty_q, vdirty_d;

  always_comb begin
    kind_d   = RSP_IDLE;
    ppn_d    = ppn_q;
    dirty_d  = dirty_q;
    vict_d   = vict_q;
    vdirty_d = vdirty_q;
    if (hit) begin
      kind_d   = RSP_HIT;
      ppn_d    = a_ppn;
      dirty_d  = a_dirty;
      vict_d   = '0;
      vdirty_d = 1'b0;
    end else if (miss) begin
      kind_d   = pick_evict ? RSP_EVICT : RSP_FILL;
      ppn_d    = fill_ppn;
      dirty_d  = req_write;
      vict_d   = pick_evict ? pick_vpn : '0;
      vdirty_d = pick_evict & c_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RSP_IDLE;
    end else begin
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppn_q    <= '0;
      dirty_q  <= 1'b0;
      vict_q   <= '0;
      vdirty_q <= 1'b0;
    end else if (req_valid) begin
      ppn_q    <= ppn_d;
      dirty_q  <= dirty_d;
      vict_q   <= vict_d;
      vdirty_q <= vdirty_d;
    end
  end

  assign rsp_valid   = (kind_q != RSP_IDLE);
  assign rsp_fault   = (kind_q == RSP_FILL) | (kind_q == RSP_EVICT);
  assign evict_valid = (kind_q == RSP_EVICT);
  assign rsp_ppn     = ppn_q;
  assign rsp_dirty   = dirty_q;
  assign evict_vpn   = vict_q;
  assign evict_dirty = vdirty_q;

endmodule

// File: rtl/pgtbl_mgr_chk.sv
module pgtbl_mgr_chk #(
  parameter int NUM_FRAMES = 4,
  parameter int FRAME_BASE = 2,
  parameter int PPN_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PPN_W-1:0] rsp_ppn,
  input logic             rsp_dirty,
  input logic             evict_valid
);

  // R9
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R10
  evict_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (rsp_valid && rsp_fault));

  // R10
  ppn_in_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((int'(rsp_ppn) >= FRAME_BASE) && (int'(rsp_ppn) < FRAME_BASE + NUM_FRAMES)));

  // R4
  fill_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_dirty == $past(req_write)));

  // R2
  hit_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> !evict_valid);

endmodule

bind pgtbl_mgr pgtbl_mgr_chk #(
  .NUM_FRAMES (NUM_FRAMES),
  .FRAME_BASE (FRAME_BASE),
  .PPN_W      (PPN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .rsp_valid   (rsp_valid),
  .rsp_fault   (rsp_fault),
  .rsp_ppn     (rsp_ppn),
  .rsp_dirty   (rsp_dirty),
  .evict_valid (evict_valid)
);

// File: tb/pgtbl_mgr_tb.sv
module pgtbl_mgr_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV   = 8;
  localparam int NF   = 4;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, touch_valid, dirty_valid;
  logic [2:0] req_vpn, touch_vpn, dirty_vpn;
  logic       rsp_valid, rsp_fault, rsp_dirty, evict_valid, evict_dirty;
  logic [2:0] rsp_ppn, evict_vpn;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgtbl_mgr u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_vpn     (req_vpn),
    .req_write   (req_write),
    .touch_valid (touch_valid),
    .touch_vpn   (touch_vpn),
    .dirty_valid (dirty_valid),
    .dirty_vpn   (dirty_vpn),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_ppn     (rsp_ppn),
    .rsp_dirty   (rsp_dirty),
    .evict_valid (evict_valid),
    .evict_vpn   (evict_vpn),
    .evict_dirty (evict_dirty)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference model built from the requirements
  bit m_valid [NV];
  bit m_dirty [NV];
  int m_ppn   [NV];
  int m_stamp [NV];
  int m_fill;
  int m_tick;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lru_victim();
    int best = -1;
    for (int v = 0; v < NV; v++) begin
      if (m_valid[v] && (best < 0 || m_stamp[v] < m_stamp[best])) best = v;
    end
    return best;
  endfunction

  function automatic int in_pool(int p);
    return ((p >= BASE) && (p < BASE + NF)) ? 1 : 0;
  endfunction

  task automatic model_reset();
    for (int v = 0; v < NV; v++) begin
      m_valid[v] = 0; m_dirty[v] = 0; m_ppn[v] = 0; m_stamp[v] = 0;
    end
    m_fill = 0;
    m_tick = 0;
  endtask

  task automatic do_req(int vpn, bit wr);
    int e_fault, e_ppn, e_dirty, e_ev, e_evvpn, e_evd;
    string tag;
    m_tick++;
    if (m_valid[vpn]) begin
      tag = "R2"; e_fault = 0; e_ppn = m_ppn[vpn]; e_dirty = m_dirty[vpn];
      e_ev = 0; e_evvpn = 0; e_evd = 0;
    end else if (m_fill < NF) begin
      tag = "R3"; e_fault = 1; e_ppn = BASE + m_fill; e_dirty = wr;
      e_ev = 0; e_evvpn = 0; e_evd = 0;
      m_fill++;
    end else begin
      tag = "R5"; e_fault = 1; e_evvpn = lru_victim();
      e_ppn = m_ppn[e_evvpn]; e_dirty = wr; e_ev = 1; e_evd = m_dirty[e_evvpn];
      m_valid[e_evvpn] = 0; m_dirty[e_evvpn] = 0;
    end
    if (e_fault == 1) begin
      m_valid[vpn] = 1; m_dirty[vpn] = wr; m_ppn[vpn] = e_ppn;
    end
    m_stamp[vpn] = m_tick;

    req_valid = 1'b1; req_vpn = 3'(vpn); req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R9 rsp_valid", int'(rsp_valid), 1);
    chk({tag, " rsp_fault"}, int'(rsp_fault), e_fault);
    chk({tag, " rsp_ppn"}, int'(rsp_ppn), e_ppn);
    chk((e_fault == 1) ? "R4 rsp_dirty" : "R2 rsp_dirty", int'(rsp_dirty), e_dirty);
    chk({tag, " evict_valid"}, int'(evict_valid), e_ev);
    if (e_ev == 1) begin
      chk("R5 evict_vpn", int'(evict_vpn), e_evvpn);
      chk("R5 evict_dirty", int'(evict_dirty), e_evd);
    end
    chk("R10 ppn in pool", in_pool(int'(rsp_ppn)), 1);
  endtask

  task automatic do_touch(int vpn);
    if (m_valid[vpn]) begin
      m_tick++;
      m_stamp[vpn] = m_tick;
    end
    touch_valid = 1'b1; touch_vpn = 3'(vpn);
    @(negedge clk);
    touch_valid = 1'b0;
    chk("R9 no rsp after touch", int'(rsp_valid), 0);
  endtask

  task automatic do_dirty(int vpn);
    if (m_valid[vpn]) m_dirty[vpn] = 1;
    dirty_valid = 1'b1; dirty_vpn = 3'(vpn);
    @(negedge clk);
    dirty_valid = 1'b0;
    chk("R9 no rsp after dirty mark", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int op, vpn;
    rst_n = 1'b0;
    req_valid = 1'b0; req_vpn = '0; req_write = 1'b0;
    touch_valid = 1'b0; touch_vpn = '0;
    dirty_valid = 1'b0; dirty_vpn = '0;
    model_reset();
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and first access
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 evict_valid after reset", int'(evict_valid), 0);
    do_req(5, 0);
    chk("R1 first lookup faults", int'(rsp_fault), 1);

    // R3/R4: remaining free frames in order, one by a write
    do_req(7, 0);
    do_req(1, 0);
    do_req(6, 1);
    chk("R4 write fault sets dirty", int'(rsp_dirty), 1);

    // R2: write hit leaves dirty clear
    do_req(5, 1);
    chk("R2 write hit keeps dirty", int'(rsp_dirty), 0);

    // R8: dirty mark on resident, then on absent page
    do_dirty(5);
    do_req(5, 0);
    chk("R8 dirty mark seen on hit", int'(rsp_dirty), 1);
    do_dirty(3);

    // R7: touch moves page 7 off the victim slot, so page 1 goes
    do_touch(7);
    do_req(3, 0);
    chk("R7 touched page not evicted", int'(evict_vpn), 1);
    chk("R8 absent page mark ignored", int'(rsp_dirty), 0);

    // R6: evicted page refaults
    do_req(1, 0);
    chk("R6 victim refaults", int'(rsp_fault), 1);

    // R7: touch of absent page changes nothing (model keeps order)
    do_touch(2);
    do_req(0, 1);
    chk("R7 absent touch no effect", int'(evict_valid), 1);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      op  = $urandom_range(0, 9);
      vpn = $urandom_range(0, NV - 1);
      if (op < 6)      do_req(vpn, 1'($urandom_range(0, 1)));
      else if (op < 8) do_touch(vpn);
      else             do_dirty(vpn);
    end

    // R1: reset in the middle of activity clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk("R1 rsp_valid after second reset", int'(rsp_valid), 0);
    do_req(4, 0);
    chk("R1 fault after second reset", int'(rsp_ppn), BASE);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule